// File: doc/BRIEF.md
# Security Unlock Sequencer

This block guards write access to a card's three memories. It keeps a small retry counter and a multi-byte secret reference. A host unlocks the card with a fixed procedure. It first writes the retry counter, and without access that write may only clear counter bits. It then presents every reference byte, one compare command per byte, in ascending address order. If each presented byte matches, a sticky access flag is set and stays set until the next reset, which stands for power-up. A mismatch, a wrong or repeated address, any other command inside the sequence, or a malformed command ends the attempt. The host must then start again from a counter write. When the counter reaches zero without access, every later compare is blocked for good.

The serial front end delivers decoded command events: an operation code, an address byte, a data byte and a flag that says the frame held exactly 24 bits. While access is denied, reads of the security bytes return zero in place of the reference bytes. The counter byte always shows only its low counter bits. A compare keeps `busy` high for a fixed number of cycles whether it matches or not, and commands offered while `busy` is high are discarded. At reset the stored counter and reference take the values of the parameters `INIT_CNT` and `INIT_REF`. Byte k of the reference (k counted from 1) sits at address k and is held in `INIT_REF[8k-1:8k-8]`.

Top module: `sec_unlock`

## Requirements
- R1: After reset, `access_granted`, `locked_out` and `busy` are 0, and reading address 0 returns `INIT_CNT` with all higher bits zero.
- R2: Operation codes are 0 = read or other non-write command, 1 = compare, 2 = security-memory update, 3 = any other write command. Without access, a full-length update to address 0 is accepted only when it clears counter bits without setting any (the new value may also equal the old one). An accepted update with a nonzero new value arms the procedure. An update that would set a bit leaves the counter unchanged.
- R3: After arming, full-length compares to addresses 1, 2 and 3 in that order, each carrying the matching reference byte, set `access_granted`.
- R4: A compare to an address other than the next expected one, or any command accepted between arming and the last compare, returns the procedure to idle without granting access.
- R5: A compare whose byte mismatches returns the procedure to idle, and a later correct compare has no effect until the counter is written again.
- R6: With access denied and a counter of zero, `locked_out` is 1 and stays 1 until reset, and compares never grant access.
- R7: Every compare, matching or not, holds `busy` high for exactly `CMP_CYCLES` cycles. Its result takes effect when `busy` falls.
- R8: Once set, `access_granted` stays 1 until reset. With access, the counter may be written to any value, including setting bits, and reference bytes may be updated.
- R9: Without access, reads of addresses 1 to 3 return 0x00. With access, they return the stored reference bytes. Address 0 always reads zero above the counter bits.
- R10: A command flagged as not exactly 24 bits changes no stored byte and returns the procedure to idle.
- R11: Updates to reference addresses without access, and updates to addresses above 3 with access, leave all stored bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cmd_valid | input | 1 | One-cycle decoded command strobe |
| cmd_op | input | 2 | Operation code, see R2 |
| cmd_addr | input | 8 | Command address byte |
| cmd_data | input | 8 | Command data byte |
| cmd_full | input | 1 | Frame held exactly 24 bits |
| rd_addr | input | 2 | Security-memory read address |
| rd_data | output | 8 | Masked security-memory read data |
| busy | output | 1 | Compare in progress |
| access_granted | output | 1 | Sticky write-access flag |
| locked_out | output | 1 | Retry counter exhausted without access |

## Verification
The bench builds the block with three reference bytes, a three-bit counter and a four-cycle compare. These defaults are small enough that a counter can be run down to zero within a handful of attempts, so the permanent lockout is reached. Every position in the compare sequence can be broken in turn: a mismatch on the last byte, a command slipped in after the first byte, and a skipped first address. The compare length of four cycles also makes the equal-timing rule observable as a count of `busy` cycles.

// File: rtl/sec_unlock_pkg.sv
package sec_unlock_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_CMP   = 2'd1,
    OP_SECWR = 2'd2,
    OP_OTHER = 2'd3
  } op_e;

  // True when moving from old_v to new_v sets no bit.
  function automatic logic only_clears(input logic [BYTE_W-1:0] old_v,
                                       input logic [BYTE_W-1:0] new_v);
    return (new_v & ~old_v) == '0;
  endfunction

  // Reference byte as seen by a reader.
  function automatic logic [BYTE_W-1:0] mask_ref(input logic [BYTE_W-1:0] v,
                                                 input logic open_v);
    return open_v ? v : '0;
  endfunction

endpackage

// File: rtl/sec_cmp_timer.sv
module sec_cmp_timer #(
  parameter int CMP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CMP_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CMP_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (start_i && !busy_o) cnt_q <= LOAD;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));

  // R7: a running compare never ends before its last cycle
  p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
  // R7: busy falls right after the last cycle
  p_busy_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
endmodule

// File: rtl/sec_store.sv
module sec_store
  import sec_unlock_pkg::*;
#(
  parameter int REF_BYTES = 3,
  parameter int CNT_BITS  = 3,
  parameter logic [REF_BYTES*8-1:0] INIT_REF = '0,
  parameter logic [CNT_BITS-1:0]    INIT_CNT = '1,
  localparam int SEL_W = $clog2(REF_BYTES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [7:0]               cmd_addr,
  input  logic [7:0]               cmd_data,
  input  logic                     cmd_full,
  input  logic                     busy_i,
  input  logic                     granted_i,
  input  logic [SEL_W-1:0]         rd_addr,
  output logic [7:0]               rd_data,
  output logic [REF_BYTES*8-1:0]   ref_o,
  output logic                     cnt_arm_o,
  output logic                     locked_o
);
  logic [CNT_BITS-1:0] cnt_q;
  logic [7:0]          ref_q [REF_BYTES];
  logic                wr_acc;
  logic                cnt_wr;
  logic [7:0]          cnt_byte;

  assign cnt_byte = {{(8-CNT_BITS){1'b0}}, cnt_q};
  assign wr_acc   = cmd_valid && !busy_i && cmd_full && (op_e'(cmd_op) == OP_SECWR);
  assign cnt_wr   = wr_acc && (cmd_addr == 8'd0) &&
                    (granted_i || only_clears(cnt_byte, {{(8-CNT_BITS){1'b0}}, cmd_data[CNT_BITS-1:0]}));
  assign cnt_arm_o = cnt_wr && (cmd_data[CNT_BITS-1:0] != '0);
  assign locked_o  = !granted_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= INIT_CNT;
    else if (cnt_wr) cnt_q <= cmd_data[CNT_BITS-1:0];
  end

  for (genvar k = 0; k < REF_BYTES; k++) begin : g_ref
    logic wr_k;
    assign wr_k = wr_acc && granted_i && (cmd_addr == 8'(k + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ref_q[k] <= INIT_REF[8*k +: 8];
      else if (wr_k) ref_q[k] <= cmd_data;
    end
    assign ref_o[8*k +: 8] = ref_q[k];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) rd_data = cnt_byte;
    for (int k = 0; k < REF_BYTES; k++)
      if (rd_addr == SEL_W'(k + 1)) rd_data = mask_ref(ref_q[k], granted_i);
  end

  // R2: without access in the previous cycle the counter only loses bits
  p_cnt_no_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(granted_i) |-> ((cnt_q & ~$past(cnt_q)) == '0));
  // R6: lockout holds once reached
  p_lock_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o);
  // R9: reference bytes hidden without access
  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!granted_i && rd_addr != '0) |-> (rd_data == 8'h00));
endmodule

// File: rtl/sec_seq.sv
module sec_seq
  import sec_unlock_pkg::*;
#(
  parameter int REF_BYTES = 3,
  localparam int SEL_W = $clog2(REF_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [7:0]             cmd_addr,
  input  logic [7:0]             cmd_data,
  input  logic                   cmd_full,
  input  logic                   busy_i,
  input  logic                   cmp_done_i,
  input  logic                   cnt_arm_i,
  input  logic                   locked_i,
  input  logic [REF_BYTES*8-1:0] ref_i,
  output logic                   cmp_start_o,
  output logic                   granted_o
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(REF_BYTES);

  logic [SEL_W-1:0] stage_q;
  logic             pend_ok_q, pend_last_q;
  logic             accept, cmp_ok;
  logic [7:0]       exp_byte;

  assign accept      = cmd_valid && !busy_i;
  assign cmp_start_o = accept && (op_e'(cmd_op) == OP_CMP);

  always_comb begin
    exp_byte = '0;
    for (int k = 1; k <= REF_BYTES; k++)
      if (stage_q == SEL_W'(k)) exp_byte = ref_i[8*(k-1) +: 8];
  end

  assign cmp_ok = cmd_full && !locked_i && (stage_q != '0) &&
                  (cmd_addr == 8'(stage_q)) && (cmd_data == exp_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q     <= '0;
      pend_ok_q   <= 1'b0;
      pend_last_q <= 1'b0;
      granted_o   <= 1'b0;
    end else begin
      if (cmp_start_o) begin
        pend_ok_q   <= cmp_ok;
        pend_last_q <= (stage_q == LAST);
      end
      if (cmp_done_i) begin
        if (pend_ok_q && pend_last_q) begin
          granted_o <= 1'b1;
          stage_q   <= '0;
        end else if (pend_ok_q) begin
          stage_q <= stage_q + 1'b1;
        end else begin
          stage_q <= '0;
        end
      end else if (accept && !cmp_start_o) begin
        stage_q <= cnt_arm_i ? SEL_W'(1) : '0;
      end
    end
  end

  // R8: access is sticky
  p_grant_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    granted_o |=> granted_o);
  // R3: access only appears at the end of the last compare
  p_grant_at_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted_o) |-> $past(cmp_done_i && stage_q == LAST));
  // R4: the stage never moves while a compare is running
  p_stage_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !cmp_done_i) |=> $stable(stage_q));
endmodule

// File: rtl/sec_unlock.sv
module sec_unlock
  import sec_unlock_pkg::*;
#(
  parameter int REF_BYTES  = 3,
  parameter int CNT_BITS   = 3,
  parameter int CMP_CYCLES = 4,
  parameter logic [REF_BYTES*8-1:0] INIT_REF = 24'hC35A17,
  parameter logic [CNT_BITS-1:0]    INIT_CNT = 3'b111,
  localparam int SEL_W = $clog2(REF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_addr,
  input  logic [7:0]       cmd_data,
  input  logic             cmd_full,
  input  logic [SEL_W-1:0] rd_addr,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             access_granted,
  output logic             locked_out
);
  logic                   cmp_start, cmp_done, cnt_arm;
  logic [REF_BYTES*8-1:0] ref_w;

  sec_cmp_timer #(.CMP_CYCLES(CMP_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(cmp_start),
    .busy_o(busy), .done_o(cmp_done)
  );

  sec_store #(
    .REF_BYTES(REF_BYTES), .CNT_BITS(CNT_BITS),
    .INIT_REF(INIT_REF), .INIT_CNT(INIT_CNT)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_full(cmd_full),
    .busy_i(busy), .granted_i(access_granted), .rd_addr(rd_addr),
    .rd_data(rd_data), .ref_o(ref_w), .cnt_arm_o(cnt_arm), .locked_o(locked_out)
  );

  sec_seq #(.REF_BYTES(REF_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_full(cmd_full),
    .busy_i(busy), .cmp_done_i(cmp_done), .cnt_arm_i(cnt_arm),
    .locked_i(locked_out), .ref_i(ref_w), .cmp_start_o(cmp_start),
    .granted_o(access_granted)
  );

  // R6: exhausted counter and access are exclusive at the ports
  p_locked_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked_out |-> !access_granted);
endmodule

// File: tb/sec_unlock_bench.sv
module sec_unlock_bench;
  localparam int CMPC = 4;
  localparam int NV   = 16;

  logic       clk = 0, rst_n = 0;
  logic       cmd_valid = 0, cmd_full = 0;
  logic [1:0] cmd_op = 0, rd_addr = 0;
  logic [7:0] cmd_addr = 0, cmd_data = 0, rd_data;
  logic       busy, access_granted, locked_out;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sec_unlock #(.REF_BYTES(3), .CNT_BITS(3), .CMP_CYCLES(CMPC),
               .INIT_REF(24'hC35A17), .INIT_CNT(3'b111)) u_sec_unlock (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_full(cmd_full),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .access_granted(access_granted), .locked_out(locked_out));

  // {op, addr, data, full, exp_granted, exp_locked, exp_cnt}
  localparam logic [23:0] VEC [NV] = '{
    {2'd2, 8'h00, 8'h06, 1'b1, 1'b0, 1'b0, 3'd6}, // R2 clear bit0, arm
    {2'd1, 8'h01, 8'h17, 1'b1, 1'b0, 1'b0, 3'd6},
    {2'd1, 8'h02, 8'h5A, 1'b1, 1'b0, 1'b0, 3'd6},
    {2'd1, 8'h03, 8'hFF, 1'b1, 1'b0, 1'b0, 3'd6}, // R5 mismatch
    {2'd1, 8'h03, 8'hC3, 1'b1, 1'b0, 1'b0, 3'd6}, // R5 no rearm
    {2'd2, 8'h00, 8'h07, 1'b1, 1'b0, 1'b0, 3'd6}, // R2 set rejected
    {2'd2, 8'h00, 8'h04, 1'b1, 1'b0, 1'b0, 3'd4},
    {2'd1, 8'h01, 8'h17, 1'b1, 1'b0, 1'b0, 3'd4},
    {2'd0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 3'd4}, // R4 interleaved
    {2'd1, 8'h02, 8'h5A, 1'b1, 1'b0, 1'b0, 3'd4},
    {2'd1, 8'h03, 8'hC3, 1'b1, 1'b0, 1'b0, 3'd4},
    {2'd2, 8'h00, 8'h04, 1'b1, 1'b0, 1'b0, 3'd4}, // R2 equal value
    {2'd1, 8'h02, 8'h5A, 1'b1, 1'b0, 1'b0, 3'd4}, // R4 skipped addr
    {2'd2, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 3'd0}, // R6 exhausted
    {2'd1, 8'h01, 8'h17, 1'b1, 1'b0, 1'b1, 3'd0},
    {2'd2, 8'h00, 8'h01, 1'b1, 1'b0, 1'b1, 3'd0}  // R6 stays locked
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                      input logic full, output int bcyc);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_full = full;
    @(negedge clk);
    cmd_valid = 0;
    bcyc = 0;
    while (busy) begin bcyc++; @(negedge clk); end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int b0, b1;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][23:22], VEC[i][21:14], VEC[i][13:6], VEC[i][5], b0);
      chk("R3/R4 granted", {7'd0, access_granted}, {7'd0, VEC[i][4]});
      chk("R6 locked", {7'd0, locked_out}, {7'd0, VEC[i][3]});
      rd(2'd0, v);
      chk("R2 counter", v, {5'd0, VEC[i][2:0]});
    end

    // reset reloads stored contents
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 granted", {7'd0, access_granted}, 8'd0);
    chk("R1 locked", {7'd0, locked_out}, 8'd0);
    chk("R1 busy", {7'd0, busy}, 8'd0);
    rd(2'd0, v); chk("R1 counter", v, 8'h07);
    for (int k = 1; k <= 3; k++) begin rd(2'(k), v); chk("R9 masked", v, 8'h00); end

    send(2'd2, 8'h00, 8'h03, 1'b0, b0);
    rd(2'd0, v); chk("R10 short write", v, 8'h07);
    send(2'd2, 8'h00, 8'h03, 1'b1, b0);
    send(2'd1, 8'h01, 8'h17, 1'b0, b0);
    send(2'd1, 8'h02, 8'h5A, 1'b1, b0);
    send(2'd1, 8'h03, 8'hC3, 1'b1, b0);
    chk("R10 short compare", {7'd0, access_granted}, 8'd0);
    send(2'd2, 8'h01, 8'h00, 1'b1, b0); // R11 no access, checked after grant

    send(2'd2, 8'h00, 8'h01, 1'b1, b0);
    send(2'd1, 8'h01, 8'h17, 1'b1, b0);
    send(2'd1, 8'h02, 8'h00, 1'b1, b1);
    chk("R7 match cycles", 8'(b0), 8'(CMPC));
    chk("R7 mismatch cycles", 8'(b1), 8'(CMPC));

    send(2'd2, 8'h00, 8'h01, 1'b1, b0);
    send(2'd1, 8'h01, 8'h17, 1'b1, b0);
    send(2'd1, 8'h02, 8'h5A, 1'b1, b0);
    chk("R3 not yet", {7'd0, access_granted}, 8'd0);
    send(2'd1, 8'h03, 8'hC3, 1'b1, b0);
    chk("R3 granted", {7'd0, access_granted}, 8'd1);
    rd(2'd1, v); chk("R9/R11 byte1", v, 8'h17);
    rd(2'd2, v); chk("R9 byte2", v, 8'h5A);
    rd(2'd3, v); chk("R9 byte3", v, 8'hC3);

    send(2'd2, 8'h00, 8'h07, 1'b1, b0);
    rd(2'd0, v); chk("R8 counter set", v, 8'h07);
    send(2'd2, 8'h02, 8'hAA, 1'b1, b0);
    rd(2'd2, v); chk("R8 ref update", v, 8'hAA);
    send(2'd2, 8'h05, 8'h00, 1'b1, b0);
    rd(2'd1, v); chk("R11 high addr b1", v, 8'h17);
    rd(2'd2, v); chk("R11 high addr b2", v, 8'hAA);
    rd(2'd3, v); chk("R11 high addr b3", v, 8'hC3);
    send(2'd1, 8'h01, 8'h00, 1'b1, b0);
    chk("R8 sticky", {7'd0, access_granted}, 8'd1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule